// File: doc/BRIEF.md
# Blitter Pixel Address Stepper

This block walks a pixel pointer across a two-dimensional window for a blit engine and turns each pointer position into a linear byte address. The pointer has an X and a Y coordinate. Each is a signed 16-bit integer with a 16-bit fraction. An inner-loop strobe moves the pointer by one pixel or phrase step, following a programmed X mode and Y add setting. An outer-loop strobe applies a row step to the pointer. Every accepted advance produces one registered byte address.

The address is built from five parts: a base address, a window width held as a 6-bit mini-float code, a pixel depth of 2^n bits, the pointer, and a phrase pitch that leaves gaps between phrases in memory. A phrase is 64 bits. Software-side setup arrives through a register-load port that writes one 32-bit register per cycle. In every 32-bit register the low half belongs to X and the high half to Y.

The address output has no ready input. The consumer takes `addr` in the cycle where `addr_valid` is high, and there is no back-pressure. A load in the same cycle as an advance drops the advance.

Top module: `pix_addr_stepper`

## Requirements
- R1: The depth field n (config bits 2:0) makes a pixel 2^n bits wide. Codes 6 and 7 act as 5. With pitch code 0, the address is base + ((Y*W + X) * 2^n) / 8, rounded toward minus infinity, where W is the decoded width.
- R2: The width code (config bits 10:5) splits into exponent e (bits 10:7) and mantissa m (bits 6:5). W = ((4+m) << e) >> 2, so code 13 gives 10 and code 20 gives 32.
- R3: X mode 0 (config bits 12:11 = 0) does three things on an inner step. It adds P = 64 >> n to the X integer, rounds X down to a multiple of P, and clears the X fraction.
- R4: X mode 1 adds 1 to the X integer when the X sign bit (config bit 13) is 0, and subtracts 1 when it is 1. The X fraction is kept.
- R5: X mode 2 leaves X unchanged on an inner step. In modes 0 to 2, the Y add bit (config bit 14) controls Y. When it is set, an inner step adds 1 to the Y integer, or subtracts 1 if the Y sign bit (config bit 15) is set. When it is clear, Y is left alone.
- R6: X mode 3 adds the increment register (integer in select 6, fraction in select 7) to both X and Y. The add spans the fraction and the integer. The Y add bit has no effect in this mode.
- R7: Pitch code p (config bits 4:3) spaces consecutive pixel phrases by 1, 2, 4 or 3 phrases of 8 bytes, for p = 0, 1, 2 and 3. The byte offset inside a phrase is unchanged.
- R8: On an outer step, config bit 16 enables adding the integer step (select 4) and config bit 17 enables adding the fractional step (select 5). A carry out of the fraction goes into the integer.
- R9: `addr_valid` is high for exactly the cycle after each accepted advance. `addr` then shows the address of the updated pointer, and holds its value when there is no advance.
- R10: A load takes priority. When `load_valid` is high, a simultaneous advance is dropped: there is no `addr_valid` and no pointer change. The load selects are: 0 base, 1 config, 2 pointer integer, 3 pointer fraction, 4 step integer, 5 step fraction, 6 increment integer, 7 increment fraction.
- R11: After reset, every register and the pointer are zero, `addr` is 0 and `addr_valid` is low.
- R12: When both strobes are high, the inner step is applied first and the outer step is applied to its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Write `load_data` into the register chosen by `load_sel` |
| load_sel | input | 3 | Register select |
| load_data | input | 32 | Register data: X in the low half, Y in the high half |
| adv_inner | input | 1 | Inner-loop step strobe |
| adv_outer | input | 1 | Outer-loop step strobe |
| addr_valid | output | 1 | Address valid, one cycle after an accepted advance |
| addr | output | 32 | Registered byte address |

## Verification
The assertions check the timing rules on every cycle. `addr_valid` follows each accepted advance by exactly one cycle, it stays low after idle cycles and after loads, and `addr` holds its value whenever no advance is accepted. The arithmetic can only be shown by the bench scenarios, which compare the output against a reference pointer model. This covers phrase truncation, sign handling, increment mode overriding the Y add bit, fraction carries, the mini-float width decode and the odd pitch ordering.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [1:0] {
    XM_PHRASE = 2'd0,
    XM_PIXEL  = 2'd1,
    XM_HOLD   = 2'd2,
    XM_INC    = 2'd3
  } xmode_e;

  typedef enum logic [2:0] {
    SEL_BASE      = 3'd0,
    SEL_CFG       = 3'd1,
    SEL_PTR_INT   = 3'd2,
    SEL_PTR_FRAC  = 3'd3,
    SEL_STEP_INT  = 3'd4,
    SEL_STEP_FRAC = 3'd5,
    SEL_INC_INT   = 3'd6,
    SEL_INC_FRAC  = 3'd7
  } sel_e;

  typedef struct packed {
    logic       upd_frac;
    logic       upd_int;
    logic       ysign;
    logic       yadd;
    logic       xsign;
    xmode_e     xmode;
    logic [5:0] wcode;
    logic [1:0] pitch;
    logic [2:0] depth;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic [2:0] dep_clamp(input logic [2:0] d);
    return (d > 3'd5) ? 3'd5 : d;
  endfunction

  // mini-float width: ((4+m) << e) >> 2
  function automatic logic [19:0] wid_pix(input logic [5:0] c);
    logic [19:0] t;
    t = 20'(3'd4 + {1'b0, c[1:0]}) << c[5:2];
    return t >> 2;
  endfunction

endpackage

// File: rtl/pas_regs.sv
module pas_regs
  import pas_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [2:0]       load_sel,
  input  logic [REG_W-1:0] load_data,
  output logic [REG_W-1:0] base_q,
  output cfg_t             cfg_q,
  output logic [REG_W-1:0] step_i_q,
  output logic [REG_W-1:0] step_f_q,
  output logic [REG_W-1:0] inc_i_q,
  output logic [REG_W-1:0] inc_f_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      cfg_q    <= '0;
      step_i_q <= '0;
      step_f_q <= '0;
      inc_i_q  <= '0;
      inc_f_q  <= '0;
    end else if (load_valid) begin
      case (sel_e'(load_sel))
        SEL_BASE:      base_q   <= load_data;
        SEL_CFG:       cfg_q    <= cfg_t'(load_data[CFG_W-1:0]);
        SEL_STEP_INT:  step_i_q <= load_data;
        SEL_STEP_FRAC: step_f_q <= load_data;
        SEL_INC_INT:   inc_i_q  <= load_data;
        SEL_INC_FRAC:  inc_f_q  <= load_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pas_stepper.sv
module pas_stepper
  import pas_pkg::*;
#(
  parameter int AXIS_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          depth,
  input  xmode_e              xmode,
  input  logic                xsign,
  input  logic                yadd,
  input  logic                ysign,
  input  logic                upd_int,
  input  logic                upd_frac,
  input  logic [2*AXIS_W-1:0] step_i,
  input  logic [2*FRAC_W-1:0] step_f,
  input  logic [2*AXIS_W-1:0] inc_i,
  input  logic [2*FRAC_W-1:0] inc_f,
  input  logic                ld_int,
  input  logic                ld_frac,
  input  logic [2*AXIS_W-1:0] ld_int_data,
  input  logic [2*FRAC_W-1:0] ld_frac_data,
  input  logic                do_inner,
  input  logic                do_outer,
  output logic [AXIS_W-1:0]   x_nxt,
  output logic [AXIS_W-1:0]   y_nxt
);

  localparam int FX_W = AXIS_W + FRAC_W;
  localparam logic [FX_W-1:0] ONE = FX_W'(1) << FRAC_W;

  logic [FX_W-1:0] p_q [2];
  logic [FX_W-1:0] p_a [2];
  logic [FX_W-1:0] p_n [2];
  logic [AXIS_W-1:0] ppp, xi;
  logic [FX_W-1:0] incx, incy;

  assign incx = {inc_i[AXIS_W-1:0], inc_f[FRAC_W-1:0]};
  assign incy = {inc_i[2*AXIS_W-1:AXIS_W], inc_f[2*FRAC_W-1:FRAC_W]};
  assign ppp  = AXIS_W'(7'd64 >> dep_clamp(depth));

  // inner stage
  always_comb begin
    p_a[0] = p_q[0];
    p_a[1] = p_q[1];
    xi     = p_q[0][FX_W-1:FRAC_W] + ppp;
    if (do_inner) begin
      case (xmode)
        XM_PHRASE: p_a[0] = {xi & ~(ppp - AXIS_W'(1)), {FRAC_W{1'b0}}};
        XM_PIXEL:  p_a[0] = xsign ? (p_q[0] - ONE) : (p_q[0] + ONE);
        XM_INC:    p_a[0] = p_q[0] + incx;
        default:   p_a[0] = p_q[0];
      endcase
      if (xmode == XM_INC)
        p_a[1] = p_q[1] + incy;
      else if (yadd)
        p_a[1] = ysign ? (p_q[1] - ONE) : (p_q[1] + ONE);
    end
  end

  // outer stage and pointer register, one per axis
  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic [FX_W-1:0] q;
    logic [FX_W-1:0] stp;
    assign stp = {upd_int  ? step_i[g*AXIS_W +: AXIS_W] : {AXIS_W{1'b0}},
                  upd_frac ? step_f[g*FRAC_W +: FRAC_W] : {FRAC_W{1'b0}}};
    assign p_n[g] = do_outer ? (p_a[g] + stp) : p_a[g];
    assign p_q[g] = q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        if (ld_int)  q[FX_W-1:FRAC_W] <= ld_int_data[g*AXIS_W +: AXIS_W];
        if (ld_frac) q[FRAC_W-1:0]    <= ld_frac_data[g*FRAC_W +: FRAC_W];
        if (!ld_int && !ld_frac && (do_inner || do_outer)) q <= p_n[g];
      end
    end
  end

  assign x_nxt = p_n[0][FX_W-1:FRAC_W];
  assign y_nxt = p_n[1][FX_W-1:FRAC_W];

endmodule

// File: rtl/pas_addr.sv
module pas_addr
  import pas_pkg::*;
#(
  parameter int AXIS_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        depth,
  input  logic [1:0]        pitch,
  input  logic [5:0]        wcode,
  input  logic [AXIS_W-1:0] x,
  input  logic [AXIS_W-1:0] y,
  output logic [ADDR_W-1:0] addr
);

  localparam int LIN_W = 2 * AXIS_W + 24;

  logic signed [LIN_W-1:0] xs, ys, ws, lin, bo, phr, off;
  logic [2:0] mul;
  logic unused_hi;

  always_comb begin
    xs  = {{(LIN_W-AXIS_W){x[AXIS_W-1]}}, x};
    ys  = {{(LIN_W-AXIS_W){y[AXIS_W-1]}}, y};
    ws  = LIN_W'(wid_pix(wcode));
    lin = ys * ws + xs;
    bo  = lin <<< dep_clamp(depth);
    phr = bo >>> 6;
    case (pitch)
      2'd0:    mul = 3'd1;
      2'd1:    mul = 3'd2;
      2'd2:    mul = 3'd4;
      default: mul = 3'd3;
    endcase
    off = ((phr * LIN_W'(mul)) <<< 3) + LIN_W'(bo[5:3]);
  end

  assign addr      = base + off[ADDR_W-1:0];
  assign unused_hi = ^off[LIN_W-1:ADDR_W];

endmodule

// File: rtl/pix_addr_stepper.sv
module pix_addr_stepper
  import pas_pkg::*;
#(
  parameter int AXIS_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_valid,
  input  logic [2:0]          load_sel,
  input  logic [2*AXIS_W-1:0] load_data,
  input  logic                adv_inner,
  input  logic                adv_outer,
  output logic                addr_valid,
  output logic [2*AXIS_W-1:0] addr
);

  localparam int REG_W  = 2 * AXIS_W;
  localparam int FRAC_W = AXIS_W;

  logic [REG_W-1:0] base_q, step_i_q, step_f_q, inc_i_q, inc_f_q;
  cfg_t             cfg_q;
  logic             do_inner, do_outer, ld_int, ld_frac;
  logic [AXIS_W-1:0] x_nxt, y_nxt;
  logic [REG_W-1:0] addr_c;

  assign do_inner = adv_inner && !load_valid;
  assign do_outer = adv_outer && !load_valid;
  assign ld_int   = load_valid && (load_sel == SEL_PTR_INT);
  assign ld_frac  = load_valid && (load_sel == SEL_PTR_FRAC);

  pas_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_valid(load_valid), .load_sel(load_sel), .load_data(load_data),
    .base_q(base_q), .cfg_q(cfg_q),
    .step_i_q(step_i_q), .step_f_q(step_f_q),
    .inc_i_q(inc_i_q), .inc_f_q(inc_f_q)
  );

  pas_stepper #(.AXIS_W(AXIS_W), .FRAC_W(FRAC_W)) u_step (
    .clk(clk), .rst_n(rst_n),
    .depth(cfg_q.depth), .xmode(cfg_q.xmode), .xsign(cfg_q.xsign),
    .yadd(cfg_q.yadd), .ysign(cfg_q.ysign),
    .upd_int(cfg_q.upd_int), .upd_frac(cfg_q.upd_frac),
    .step_i(step_i_q), .step_f(step_f_q),
    .inc_i(inc_i_q), .inc_f(inc_f_q),
    .ld_int(ld_int), .ld_frac(ld_frac),
    .ld_int_data(load_data), .ld_frac_data(load_data),
    .do_inner(do_inner), .do_outer(do_outer),
    .x_nxt(x_nxt), .y_nxt(y_nxt)
  );

  pas_addr #(.AXIS_W(AXIS_W), .ADDR_W(REG_W)) u_addr (
    .base(base_q), .depth(cfg_q.depth), .pitch(cfg_q.pitch),
    .wcode(cfg_q.wcode), .x(x_nxt), .y(y_nxt), .addr(addr_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
    end else begin
      addr_valid <= do_inner || do_outer;
      if (do_inner || do_outer) addr <= addr_c;
    end
  end

endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int A_W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_valid,
  input logic           adv_inner,
  input logic           adv_outer,
  input logic           addr_valid,
  input logic [A_W-1:0] addr
);

  a_r9_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
    ((adv_inner || adv_outer) && !load_valid) |=> addr_valid);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_inner && !adv_outer) |=> !addr_valid);

  a_r10_load_drops_adv: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !addr_valid);

  a_r9_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid || (!adv_inner && !adv_outer)) |=> $stable(addr));

endmodule

bind pix_addr_stepper pas_checker #(.A_W(2 * AXIS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
  .adv_inner(adv_inner), .adv_outer(adv_outer),
  .addr_valid(addr_valid), .addr(addr)
);

// File: tb/sim_pix_addr_stepper.sv
`timescale 1ns/1ps
module sim_pix_addr_stepper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [2:0]  load_sel = '0;
  logic [31:0] load_data = '0;
  logic        adv_inner = 1'b0;
  logic        adv_outer = 1'b0;
  logic        addr_valid;
  logic [31:0] addr;

  int n_chk = 0;
  int n_bad = 0;

  bit [31:0] m_base, m_cfg, m_si, m_sf, m_ii, m_if, px, py, m_addr;

  always #5 clk = ~clk;

  pix_addr_stepper u0 (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_sel(load_sel),
    .load_data(load_data), .adv_inner(adv_inner), .adv_outer(adv_outer),
    .addr_valid(addr_valid), .addr(addr)
  );

  function automatic bit [31:0] mk_cfg(int dep, int pit, int wc, int xm, int xs,
                                       int ya, int ys, int ui, int uf);
    return 32'(dep & 7) | (32'(pit & 3) << 3) | (32'(wc & 63) << 5) |
           (32'(xm & 3) << 11) | (32'(xs & 1) << 13) | (32'(ya & 1) << 14) |
           (32'(ys & 1) << 15) | (32'(ui & 1) << 16) | (32'(uf & 1) << 17);
  endfunction

  function automatic int clampn(bit [31:0] c);
    int n = int'(c[2:0]);
    return (n > 5) ? 5 : n;
  endfunction

  function automatic longint widv(bit [5:0] c);
    return ((longint'(4 + c[1:0])) << c[5:2]) >> 2;
  endfunction

  function automatic bit [31:0] exp_addr(bit [31:0] b, bit [31:0] c, bit [31:0] x, bit [31:0] y);
    longint xs = longint'($signed(x[31:16]));
    longint ys = longint'($signed(y[31:16]));
    longint lin = ys * widv(c[10:5]) + xs;
    longint bo = lin <<< clampn(c);
    longint phr = bo >>> 6;
    longint byt = (bo >>> 3) & 7;
    longint mul = (c[4:3] == 0) ? 1 : (c[4:3] == 1) ? 2 : (c[4:3] == 2) ? 4 : 3;
    return b + 32'(phr * mul * 8 + byt);
  endfunction

  task automatic model_step(bit inner, bit outer);
    bit [31:0] incx = {m_ii[15:0], m_if[15:0]};
    bit [31:0] incy = {m_ii[31:16], m_if[31:16]};
    if (inner) begin
      case (m_cfg[12:11])
        2'd0: begin
          bit [15:0] ppp = 16'(64 >> clampn(m_cfg));
          bit [15:0] xi = px[31:16] + ppp;
          px = {xi & ~(ppp - 16'd1), 16'h0};
        end
        2'd1: px = m_cfg[13] ? px - 32'h10000 : px + 32'h10000;
        2'd3: px = px + incx;
        default: ;
      endcase
      if (m_cfg[12:11] == 2'd3) py = py + incy;
      else if (m_cfg[14]) py = m_cfg[15] ? py - 32'h10000 : py + 32'h10000;
    end
    if (outer) begin
      px = px + {m_cfg[16] ? m_si[15:0] : 16'h0, m_cfg[17] ? m_sf[15:0] : 16'h0};
      py = py + {m_cfg[16] ? m_si[31:16] : 16'h0, m_cfg[17] ? m_sf[31:16] : 16'h0};
    end
  endtask

  task automatic chk(string tag, bit [31:0] got, bit [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_load(int sel, bit [31:0] d, bit ai, bit ao, string tag);
    @(negedge clk);
    load_valid = 1'b1; load_sel = 3'(sel); load_data = d;
    adv_inner = ai; adv_outer = ao;
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0; adv_inner = 1'b0; adv_outer = 1'b0;
    case (sel)
      0: m_base = d;
      1: m_cfg = d & 32'h3FFFF;
      2: begin px[31:16] = d[15:0]; py[31:16] = d[31:16]; end
      3: begin px[15:0] = d[15:0]; py[15:0] = d[31:16]; end
      4: m_si = d;
      5: m_sf = d;
      6: m_ii = d;
      default: m_if = d;
    endcase
    chk({tag, " valid after load"}, 32'(addr_valid), 32'd0);
    chk({tag, " addr held on load"}, addr, m_addr);
  endtask

  task automatic do_adv(bit ai, bit ao, string tag);
    @(negedge clk);
    adv_inner = ai; adv_outer = ao;
    @(posedge clk);
    @(negedge clk);
    adv_inner = 1'b0; adv_outer = 1'b0;
    model_step(ai, ao);
    m_addr = exp_addr(m_base, m_cfg, px, py);
    chk({tag, " valid"}, 32'(addr_valid), 32'd1);
    chk({tag, " addr"}, addr, m_addr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    {m_base, m_cfg, m_si, m_sf, m_ii, m_if, px, py, m_addr} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 reset valid", 32'(addr_valid), 32'd0);
    chk("R11 reset addr", addr, 32'd0);
    @(negedge clk);
    chk("R11 idle valid", 32'(addr_valid), 32'd0);

    // R2 width decode
    do_load(1, mk_cfg(3, 0, 13, 2, 0, 1, 0, 0, 0), 0, 0, "R2");
    do_adv(1, 0, "R2 code13");
    chk("R2 code13 literal", addr, 32'd10);
    do_load(1, mk_cfg(3, 0, 20, 2, 0, 1, 0, 0, 0), 0, 0, "R2");
    do_load(2, 32'h0, 0, 0, "R2");
    do_adv(1, 0, "R2 code20");
    chk("R2 code20 literal", addr, 32'd32);

    // R1 depth scaling
    do_load(1, mk_cfg(5, 0, 13, 2, 0, 0, 0, 0, 0), 0, 0, "R1");
    do_load(2, 32'h0000_0003, 0, 0, "R1");
    do_adv(1, 0, "R1 depth5");
    chk("R1 depth5 literal", addr, 32'd12);
    do_load(1, mk_cfg(0, 0, 13, 2, 0, 0, 0, 0, 0), 0, 0, "R1");
    do_load(2, 32'h0000_0011, 0, 0, "R1");
    do_adv(1, 0, "R1 depth0");
    chk("R1 depth0 literal", addr, 32'd2);

    // R3 phrase advance with truncation
    do_load(1, mk_cfg(3, 0, 13, 0, 0, 0, 0, 0, 1), 0, 0, "R3");
    do_load(2, 32'h0000_0003, 0, 0, "R3");
    do_load(3, 32'h0000_FFFF, 0, 0, "R3");
    do_load(5, 32'h0000_0001, 0, 0, "R3");
    do_adv(1, 0, "R3 truncate");
    chk("R3 truncate literal", addr, 32'd8);
    do_adv(1, 1, "R3 frac cleared");
    chk("R3 frac cleared literal", addr, 32'd16);

    // R4 pixel step both signs
    do_load(1, mk_cfg(3, 0, 13, 1, 1, 0, 0, 0, 0), 0, 0, "R4");
    do_adv(1, 0, "R4 minus");
    chk("R4 minus literal", addr, 32'd15);
    do_load(1, mk_cfg(3, 0, 13, 1, 0, 0, 0, 0, 0), 0, 0, "R4");
    do_adv(1, 0, "R4 plus");

    // R5 hold X, Y down
    do_load(1, mk_cfg(3, 0, 13, 2, 0, 1, 1, 0, 0), 0, 0, "R5");
    do_adv(1, 0, "R5 y minus");

    // R6 increment mode overrides Y add
    do_load(1, mk_cfg(3, 0, 13, 3, 0, 1, 0, 0, 0), 0, 0, "R6");
    do_load(2, 32'h0, 0, 0, "R6");
    do_load(3, 32'h0, 0, 0, "R6");
    do_load(6, 32'h0001_0002, 0, 0, "R6");
    do_load(7, 32'h0, 0, 0, "R6");
    do_adv(1, 0, "R6 inc");
    chk("R6 inc literal", addr, 32'd12);

    // R7 pitch ordering
    do_load(2, 32'h0000_0008, 0, 0, "R7");
    do_load(1, mk_cfg(3, 2, 13, 2, 0, 0, 0, 0, 0), 0, 0, "R7");
    do_adv(1, 0, "R7 pitch2");
    chk("R7 pitch2 literal", addr, 32'd32);
    do_load(1, mk_cfg(3, 3, 13, 2, 0, 0, 0, 0, 0), 0, 0, "R7");
    do_adv(1, 0, "R7 pitch3");
    chk("R7 pitch3 literal", addr, 32'd24);
    do_load(1, mk_cfg(3, 1, 13, 2, 0, 0, 0, 0, 0), 0, 0, "R7");
    do_adv(1, 0, "R7 pitch1");
    chk("R7 pitch1 literal", addr, 32'd16);

    // R8 outer enables and carry
    do_load(1, mk_cfg(3, 0, 13, 2, 0, 0, 0, 0, 1), 0, 0, "R8");
    do_load(2, 32'h0, 0, 0, "R8");
    do_load(4, 32'h0000_0005, 0, 0, "R8");
    do_load(5, 32'h0000_8000, 0, 0, "R8");
    do_adv(0, 1, "R8 frac half");
    chk("R8 frac half literal", addr, 32'd0);
    do_adv(0, 1, "R8 carry");
    chk("R8 carry literal", addr, 32'd1);
    do_load(1, mk_cfg(3, 0, 13, 2, 0, 0, 0, 1, 0), 0, 0, "R8");
    do_adv(0, 1, "R8 int only");
    chk("R8 int only literal", addr, 32'd6);

    // R12 both strobes: inner then outer
    do_load(1, mk_cfg(3, 0, 13, 1, 0, 0, 0, 1, 0), 0, 0, "R12");
    do_adv(1, 1, "R12 both");
    chk("R12 both literal", addr, 32'd12);

    // R10 load wins over advance
    do_load(2, 32'h0000_0020, 1, 1, "R10");
    do_adv(1, 0, "R10 after drop");
    chk("R10 after drop literal", addr, 32'd33);

    // R9 random mix against the model
    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom % 100);
      if (r < 8)
        do_load(1, mk_cfg(int'($urandom % 8), int'($urandom % 4), int'($urandom % 24),
                          int'($urandom % 4), int'($urandom % 2), int'($urandom % 2),
                          int'($urandom % 2), int'($urandom % 2), int'($urandom % 2)),
                int'($urandom % 2), int'($urandom % 2), "R10 rnd cfg");
      else if (r < 12) do_load(2, $urandom, 0, 0, "R9 rnd ptr");
      else if (r < 14) do_load(3, $urandom, 0, 0, "R9 rnd frac");
      else if (r < 16) do_load(4, $urandom, 0, 0, "R9 rnd step");
      else if (r < 17) do_load(5, $urandom, 0, 0, "R9 rnd stepf");
      else if (r < 18) do_load(6, $urandom, 0, 0, "R9 rnd inc");
      else if (r < 19) do_load(7, $urandom, 0, 0, "R9 rnd incf");
      else if (r < 20) do_load(0, $urandom, 0, 0, "R9 rnd base");
      else if (r < 25) begin
        @(negedge clk);
        chk("R9 idle valid", 32'(addr_valid), 32'd0);
        chk("R9 idle addr", addr, m_addr);
      end else begin
        int k = int'($urandom % 3);
        do_adv(k != 1, k != 0, "R9 rnd adv");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule